// File: doc/BRIEF.md
# SDRAM Bank-Activate Interlock Timer

This block sits inside a memory controller and decides whether a new bank-activate command may go out to synchronous DRAM. When a write finishes or an auto-refresh is issued, it loads a countdown. The length of that countdown is a precharge time plus a delay that depends on the event. Until the countdown reaches zero, the activate path is held off. When a write and a refresh arrive close together, the longer of the two requirements wins.

When the controller is driving conventional DRAM or pseudo-SRAM instead, the same refresh field sets the width of the refresh strobe. In conventional DRAM that strobe is RAS for a CAS-before-RAS refresh. In pseudo-SRAM it is the output-enable/refresh pin. In those modes no activate lockout is applied.

The activate request is a valid/ready handshake. The sequencer raises `act_valid` and must hold it until it sees `act_fire`. `act_ready` is the "activate allowed" flag. It may fall at any cycle in which a write-end or refresh event arrives, and a held request then simply waits. The request is granted in the first cycle after the lockout expires.

Top module: `sdram_act_interlock`

## Requirements
- R1: After reset, `act_ready` is 1, `refresh_strobe` is 0 and no lockout is running.
- R2: In synchronous DRAM mode (`mem_mode` = 2'b10), a `wr_end` pulse in cycle t drives `act_ready` low in cycle t and in the next P+W cycles. Here P = `pre_time`+1, and W is taken from `wr_rcv`: 2'b00 gives 1, 2'b01 gives 2 and 2'b10 gives 3.
- R3: In synchronous DRAM mode, a `ref_evt` pulse in cycle t drives `act_ready` low in cycle t and in the next P+F cycles. Here F = `rf_act`+2, so 2'b00..2'b11 give 2..5.
- R4: The code 2'b11 on `wr_rcv` is reserved. While it is present, `cfg_err` is 1 and W is 3. For every other code, `cfg_err` is 0.
- R5: In any mode other than 2'b10, `wr_end` and `ref_evt` never lower `act_ready`.
- R6: In conventional DRAM mode (2'b00) or pseudo-SRAM mode (2'b01), a `ref_evt` in cycle t raises `refresh_strobe` for cycles t+1 through t+F. In modes 2'b10 and 2'b11 the strobe stays low.
- R7: An event that arrives while a lockout is running leaves the remaining count at the larger of the two: the current remaining count minus one, or the new event's length. When a write and a refresh arrive in the same cycle, the longer lockout is taken.
- R8: `act_fire` = `act_valid` AND `act_ready`. A request held during a lockout fires in the first cycle in which the count is zero.
- R9: A running count drops by exactly one per cycle unless a reload raises it. It never jumps to zero early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_mode | input | 2 | 00 DRAM, 01 pseudo-SRAM, 10 synchronous DRAM, 11 other |
| wr_rcv | input | 2 | Write-recovery code |
| rf_act | input | 2 | Refresh-active code |
| pre_time | input | 2 | Precharge time minus one |
| wr_end | input | 1 | Write-cycle end strobe |
| ref_evt | input | 1 | Auto-refresh / CBR refresh strobe |
| act_valid | input | 1 | Bank-activate request |
| act_ready | output | 1 | Bank-activate allowed |
| act_fire | output | 1 | Bank-activate issued this cycle |
| refresh_strobe | output | 1 | RAS / refresh strobe window |
| cfg_err | output | 1 | Reserved write-recovery code programmed |

## Verification
The bench sweeps every combination of mode, write code and precharge time for a single write event, and every combination of mode, refresh code and precharge time for a single refresh event. For each case it counts the low cycles of `act_ready`, the cycle of the first `act_fire`, and the width and start of the strobe. A design that mis-decoded a field would be off by a cycle. A design that kept the reserved code at its raw value would show a 4-cycle recovery. A design that gated by mode incorrectly would stall DRAM traffic. Overlap runs check the cases where a reload must lengthen the lockout and where it must not shorten it. A design that simply reloaded on each event would release early.

// File: rtl/sdram_ilk_pkg.sv
package sdram_ilk_pkg;
  typedef enum logic [1:0] {
    MEM_DRAM  = 2'b00,
    MEM_PSRAM = 2'b01,
    MEM_SDRAM = 2'b10,
    MEM_OTHER = 2'b11
  } mem_kind_e;

  // Write recovery: 00->1, 01->2, 10->3, reserved 11 clamps to 3
  function automatic logic [2:0] wr_cycles(input logic [1:0] code);
    return (code == 2'b11) ? 3'd3 : {1'b0, code} + 3'd1;
  endfunction

  // Refresh active: 00..11 -> 2..5
  function automatic logic [2:0] rf_cycles(input logic [1:0] code);
    return {1'b0, code} + 3'd2;
  endfunction
endpackage

// File: rtl/ilk_decode.sv
module ilk_decode import sdram_ilk_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic [1:0]       wr_rcv,
  input  logic [1:0]       rf_act,
  input  logic [1:0]       pre_time,
  output logic [CNT_W-1:0] wr_lock_len,
  output logic [CNT_W-1:0] rf_lock_len,
  output logic [CNT_W-1:0] strobe_len,
  output logic             cfg_err
);
  logic [CNT_W-1:0] pre_len;

  always_comb begin
    pre_len     = CNT_W'(pre_time) + CNT_W'(1);
    wr_lock_len = pre_len + CNT_W'(wr_cycles(wr_rcv));
    rf_lock_len = pre_len + CNT_W'(rf_cycles(rf_act));
    strobe_len  = CNT_W'(rf_cycles(rf_act));
    cfg_err     = (wr_rcv == 2'b11);
  end
endmodule

// File: rtl/ilk_countdown.sv
module ilk_countdown #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, dec;

  always_comb dec = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load && load_val > dec)   cnt_q <= load_val;
    else                               cnt_q <= dec;
  end

  assign busy = (cnt_q != '0);

  // R9: no early release
  a_r9_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(1)) |=> (cnt_q != '0));
  // R9: steady decrement without load
  a_r9_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R7: reload never shortens below the new request
  a_r7_reload_covers: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q >= $past(load_val)));
endmodule

// File: rtl/sdram_act_interlock.sv
module sdram_act_interlock import sdram_ilk_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mem_mode,
  input  logic [1:0] wr_rcv,
  input  logic [1:0] rf_act,
  input  logic [1:0] pre_time,
  input  logic       wr_end,
  input  logic       ref_evt,
  input  logic       act_valid,
  output logic       act_ready,
  output logic       act_fire,
  output logic       refresh_strobe,
  output logic       cfg_err
);
  logic [CNT_W-1:0] wr_len, rf_len, stb_len, lock_val;
  logic is_sdram, is_dram_like, lock_load, stb_load, lock_busy;

  ilk_decode #(.CNT_W(CNT_W)) i_dec (
    .wr_rcv(wr_rcv), .rf_act(rf_act), .pre_time(pre_time),
    .wr_lock_len(wr_len), .rf_lock_len(rf_len), .strobe_len(stb_len),
    .cfg_err(cfg_err));

  always_comb begin
    is_sdram     = (mem_kind_e'(mem_mode) == MEM_SDRAM);
    is_dram_like = (mem_kind_e'(mem_mode) == MEM_DRAM) ||
                   (mem_kind_e'(mem_mode) == MEM_PSRAM);
    lock_load    = is_sdram && (wr_end || ref_evt);
    lock_val     = '0;
    if (wr_end && wr_len > lock_val)  lock_val = wr_len;
    if (ref_evt && rf_len > lock_val) lock_val = rf_len;
    stb_load     = is_dram_like && ref_evt;
  end

  ilk_countdown #(.CNT_W(CNT_W)) i_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .load_val(lock_val),
    .busy(lock_busy));

  ilk_countdown #(.CNT_W(CNT_W)) i_strobe (
    .clk(clk), .rst_n(rst_n), .load(stb_load), .load_val(stb_len),
    .busy(refresh_strobe));

  assign act_ready = !lock_busy && !lock_load;
  assign act_fire  = act_valid && act_ready;

  // R8: no activate while a lockout counts
  a_r8_no_fire_locked: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !lock_busy);
  // R5: lockout only started from synchronous DRAM mode
  a_r5_lock_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_busy) |-> $past(is_sdram));
  // R6: strobe starts only after a refresh in a DRAM-like mode
  a_r6_strobe_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_strobe) |-> ($past(ref_evt) && $past(is_dram_like)));
endmodule

// File: tb/test_sdram_act_interlock.sv
module test_sdram_act_interlock;
  logic clk = 0, rst_n = 0;
  logic [1:0] mem_mode = 0, wr_rcv = 0, rf_act = 0, pre_time = 0;
  logic wr_end = 0, ref_evt = 0, act_valid = 0;
  logic act_ready, act_fire, refresh_strobe, cfg_err;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sdram_act_interlock i_sdram_act_interlock (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // event A at cycle 0, event B at cycle b_at (-1: none)
  task automatic run(input bit a_wr, input bit a_rf, input bit b_wr, input bit b_rf,
                     input int b_at, output int lows, output int fire_at,
                     output int stb, output int stb_first);
    lows = 0; fire_at = -1; stb = 0; stb_first = -1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      act_valid = 1;
      wr_end  = (c == 0 && a_wr) || (c == b_at && b_wr);
      ref_evt = (c == 0 && a_rf) || (c == b_at && b_rf);
      #2;
      if (!act_ready) lows++;
      if (act_fire && fire_at < 0) fire_at = c;
      if (act_fire && !act_ready) check("R8 fire while blocked", 1, 0);
      if (refresh_strobe) begin
        stb++;
        if (stb_first < 0) stb_first = c;
      end
    end
    @(negedge clk);
    wr_end = 0; ref_evt = 0; act_valid = 0;
  endtask

  initial begin
    int lows, fa, stb, sf, p, w, f, n;
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lows, fa, stb, sf, p, w, f, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R1
    check("R1 ready", act_ready, 1);
    check("R1 strobe", refresh_strobe, 0);
    // write sweep: R2 R4 R5 R6
    for (int m = 0; m < 4; m++)
      for (int wc = 0; wc < 4; wc++)
        for (int pc = 0; pc < 4; pc++) begin
          mem_mode = 2'(m); wr_rcv = 2'(wc); pre_time = 2'(pc);
          #1;
          check("R4 cfg_err", cfg_err, (wc == 3) ? 1 : 0);
          run(1, 0, 0, 0, -1, lows, fa, stb, sf);
          p = pc + 1; w = (wc == 3) ? 3 : wc + 1; n = p + w;
          if (m == 2) begin
            check("R2/R4 lockout cycles", lows, n + 1);
            check("R8 fire cycle", fa, n + 1);
          end else begin
            check("R5 no write lockout", lows, 0);
            check("R8 fire at once", fa, 0);
          end
          check("R6 no strobe on write", stb, 0);
        end
    // refresh sweep: R3 R5 R6
    wr_rcv = 0;
    for (int m = 0; m < 4; m++)
      for (int rc = 0; rc < 4; rc++)
        for (int pc = 0; pc < 4; pc++) begin
          mem_mode = 2'(m); rf_act = 2'(rc); pre_time = 2'(pc);
          run(0, 1, 0, 0, -1, lows, fa, stb, sf);
          p = pc + 1; f = rc + 2; n = p + f;
          check("R3/R5 refresh lockout", lows, (m == 2) ? n + 1 : 0);
          check("R8 fire after refresh", fa, (m == 2) ? n + 1 : 0);
          check("R6 strobe width", stb, (m < 2) ? f : 0);
          if (m < 2) check("R6 strobe start", sf, 1);
        end
    // R7 overlaps, SDRAM mode
    mem_mode = 2; pre_time = 0;
    wr_rcv = 0; rf_act = 3;           // write 2, refresh 6
    run(1, 0, 0, 1, 1, lows, fa, stb, sf);
    check("R7 longer reload extends", lows, 8);
    run(0, 1, 1, 0, 2, lows, fa, stb, sf);
    check("R7 shorter reload ignored", lows, 7);
    check("R9 no early release", fa, 7);
    wr_rcv = 2; rf_act = 0;           // write 4, refresh 3
    run(1, 1, 0, 0, -1, lows, fa, stb, sf);
    check("R7 simultaneous longer wins", lows, 5);
    wr_rcv = 0; rf_act = 0;           // refresh 3, refresh at cycle 3 again
    run(0, 1, 0, 1, 3, lows, fa, stb, sf);
    check("R7 back-to-back refresh", lows, 7);
    // R6 strobe reload in DRAM mode: width 5 twice, second at cycle 2
    mem_mode = 0; rf_act = 3;
    run(0, 1, 0, 1, 2, lows, fa, stb, sf);
    check("R6 strobe stretched", stb, 7);
    check("R5 DRAM no lockout", lows, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule